// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer with Byte-Pair Access

This block is a 16-bit timer for a processor whose data bus is eight bits wide. A free-running up-counter advances once every four bus clocks. Software can read it but cannot write it. Two channels sit on that count. Each channel time-stamps an edge on its input pin, and each can change an output pin level when the count reaches a programmed value. Capture events, compare events and counter wrap-around each raise a status flag, and each flag has its own interrupt enable.

Every 16-bit quantity is reached through a high/low byte pair. Access to a pair follows a high-then-low protocol. Reading the counter's high byte freezes a copy of the low byte, so the two halves belong to the same count. Reading a capture high byte holds off new captures on that channel until its low byte is read. Writing a compare high byte stops that channel's compare until its low byte is written. A flag is cleared by a two-step sequence: read the status register while the flag is set, then access the data low byte that belongs to the flag. A parameter removes the compare pins, so the instance serves only as an interval and interrupt source. A second parameter sets the prescale ratio.

Register map (byte addresses): 0 interrupt enable, 1 mode, 2 status, 3/4 counter high/low, 5/6 capture 0 high/low, 7/8 capture 1 high/low, 9/10 compare 0 high/low, 11/12 compare 1 high/low. The flag bit order is the same in the interrupt enable register and the status register: bit 0 wrap, bit 1 capture 0, bit 2 capture 1, bit 3 compare 0, bit 4 compare 1. Mode bit i selects the capture edge of channel i (1 rising, 0 falling). Mode bit 2+i is the level that compare pin i takes on a match.

Top module: `pair_timer`

## Requirements
- R1: After reset the counter reads 0. It then increases by exactly one every PRESCALE (default 4) bus clocks, so two live low-byte reads 40 clocks apart differ by 10.
- R2: When the counter steps from 0xFFFF to 0x0000, status bit 0 is set. It is not set before the wrap.
- R3: Reading the counter changes nothing. A high-byte read (address 3) stores the low byte, and the next low-byte read (address 4) returns that stored byte. Writes to addresses 3 and 4 are ignored.
- R4: On the edge selected by mode bit i, channel i copies the counter into its capture pair and sets status bit 1+i. The opposite edge does nothing.
- R5: After a read of the capture high byte of channel i, that channel ignores edges and keeps its capture value until its capture low byte is read. Capture then resumes.
- R6: Compare matching is off after reset and both compare pins are 0. Once compare low byte i has been written, the counter reaching the compare value drives compare pin i to mode bit 2+i and sets status bit 3+i.
- R7: A write to compare high byte i stops matching on channel i until compare low byte i is written.
- R8: A flag is cleared only when a status read that saw the flag set comes before the flag's low-byte access: counter low read for bit 0, capture low read for capture bits, compare low write for compare bits. A low-byte access with no such status read leaves the flag set.
- R9: irq goes high one clock after a flag and its enable bit are both set, and it is low while every enable bit is clear.
- R10: With compare pins configured off, compare matches still set status bits 3 and 4 while the compare pin outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte address |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the clock after the read strobe |
| cap_pin | input | 2 | Capture input pins, one per channel |
| cmp_pin | output | 2 | Compare output pins, one per channel |
| irq | output | 1 | Registered interrupt request |

## Verification
Each result has a fixed latency. Read data is registered and appears one clock after the strobe edge. irq follows its flag or enable change by one clock. A pin edge reaches the capture register on the third clock edge after the pin changes, because of the two synchronizer stages and the edge register. The bench drives the bus and the pins on falling edges and samples on falling edges. It waits at least the latency above before each check, and it places the counter reads whole multiples of four clocks apart, so the expected count differences are exact rather than a range. Where the capture timestamp depends on the prescaler phase, the check accepts a small window derived from the three-clock capture latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NCH    = 2;
  localparam int NFLAG  = 1 + 2 * NCH;
  localparam int AW     = 4;

  localparam logic [AW-1:0] A_IEN   = 4'd0;
  localparam logic [AW-1:0] A_MODE  = 4'd1;
  localparam logic [AW-1:0] A_STAT  = 4'd2;
  localparam logic [AW-1:0] A_CNTH  = 4'd3;
  localparam logic [AW-1:0] A_CNTL  = 4'd4;
  localparam logic [AW-1:0] A_CAP0H = 4'd5;
  localparam logic [AW-1:0] A_CMP0H = 4'd9;

  localparam int F_WRAP = 0;
  localparam int F_CAP  = 1;
  localparam int F_CMP  = 1 + NCH;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int PRESCALE = 4,
  parameter int W        = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt,
  output logic         tick,
  output logic         wrap
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else if (phase == PW'(PRESCALE - 1)) phase <= '0;
        else phase <= phase + PW'(1);
      end
      assign tick = (phase == PW'(PRESCALE - 1));

      a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= cnt + W'(1);
  end

  assign wrap = tick && (cnt == {W{1'b1}});

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin,
  input  logic         rise_sel,
  input  logic [W-1:0] cnt,
  input  logic         hold_set,
  input  logic         hold_rel,
  input  logic         flag_clr,
  output logic [W-1:0] cap_val,
  output logic         flag
);
  logic [2:0] sync;
  logic       hold;
  logic       edge_hit;

  always_ff @(posedge clk) begin
    if (rst) sync <= '0;
    else sync <= {sync[1:0], pin};
  end

  assign edge_hit = rise_sel ? (sync[1] && !sync[2]) : (!sync[1] && sync[2]);

  always_ff @(posedge clk) begin
    if (rst) hold <= 1'b0;
    else if (hold_set) hold <= 1'b1;
    else if (hold_rel) hold <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val <= '0;
      flag    <= 1'b0;
    end else if (edge_hit && !hold) begin
      cap_val <= cnt;
      flag    <= 1'b1;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end

  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cap_val));
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !edge_hit |=> !$rose(flag));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int W      = 16,
  parameter bit PIN_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         tick,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W/2-1:0] wdata,
  input  logic         level,
  input  logic         flag_clr,
  output logic         flag,
  output logic         pin
);
  logic [W-1:0] cmp_val;
  logic         en;
  logic         hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= {W{1'b1}};
      en      <= 1'b0;
    end else if (wr_hi) begin
      cmp_val[W-1:W/2] <= wdata;
      en               <= 1'b0;
    end else if (wr_lo) begin
      cmp_val[W/2-1:0] <= wdata;
      en               <= 1'b1;
    end
  end

  assign hit = en && tick && ((cnt + W'(1)) == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  generate
    if (PIN_EN) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else if (hit) pin <= level;
      end
    end else begin : g_nopin
      assign pin = 1'b0;
    end
  endgenerate

  a_r7_off_no_match: assert property (@(posedge clk) disable iff (rst)
    !en |=> !$rose(flag));
endmodule

// File: rtl/pair_timer.sv
module pair_timer
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter bit CMP_PINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    cap_pin,
  output logic [NCH-1:0]    cmp_pin,
  output logic              irq
);
  logic [CNT_W-1:0]  cnt;
  logic              tick, wrap;
  logic [NFLAG-1:0]  ien, stat, arm, lo_acc, clr;
  logic [2*NCH-1:0]  mode;
  logic [BYTE_W-1:0] lo_copy;
  logic              lo_valid;
  logic              ovf_flag;
  logic [CNT_W-1:0]  cap_val [NCH];
  logic              stat_rd;

  tmr_counter #(.PRESCALE(PRESCALE), .W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt), .tick(tick), .wrap(wrap)
  );

  assign stat_rd   = bus_rd && (bus_addr == A_STAT);
  assign lo_acc[F_WRAP] = bus_rd && (bus_addr == A_CNTL);
  assign stat[F_WRAP]   = ovf_flag;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam logic [AW-1:0] CAPH = A_CAP0H + AW'(2 * i);
      localparam logic [AW-1:0] CAPL = CAPH + AW'(1);
      localparam logic [AW-1:0] CMPH = A_CMP0H + AW'(2 * i);
      localparam logic [AW-1:0] CMPL = CMPH + AW'(1);

      assign lo_acc[F_CAP+i] = bus_rd && (bus_addr == CAPL);
      assign lo_acc[F_CMP+i] = bus_wr && (bus_addr == CMPL);

      tmr_capture #(.W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .pin(cap_pin[i]), .rise_sel(mode[i]), .cnt(cnt),
        .hold_set(bus_rd && (bus_addr == CAPH)),
        .hold_rel(lo_acc[F_CAP+i]),
        .flag_clr(clr[F_CAP+i]),
        .cap_val(cap_val[i]), .flag(stat[F_CAP+i])
      );

      tmr_compare #(.W(CNT_W), .PIN_EN(CMP_PINS)) u_cmp (
        .clk(clk), .rst(rst), .cnt(cnt), .tick(tick),
        .wr_hi(bus_wr && (bus_addr == CMPH)),
        .wr_lo(lo_acc[F_CMP+i]),
        .wdata(bus_wdata), .level(mode[NCH+i]),
        .flag_clr(clr[F_CMP+i]),
        .flag(stat[F_CMP+i]), .pin(cmp_pin[i])
      );
    end
  endgenerate

  assign clr = lo_acc & arm;

  always_ff @(posedge clk) begin
    if (rst) arm <= '0;
    else if (stat_rd) arm <= stat;
    else arm <= arm & ~lo_acc;
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_flag <= 1'b0;
    else if (wrap) ovf_flag <= 1'b1;
    else if (clr[F_WRAP]) ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien  <= '0;
      mode <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_IEN)  ien  <= bus_wdata[NFLAG-1:0];
      if (bus_addr == A_MODE) mode <= bus_wdata[2*NCH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_copy  <= '0;
      lo_valid <= 1'b0;
    end else if (bus_rd && (bus_addr == A_CNTH)) begin
      lo_copy  <= cnt[BYTE_W-1:0];
      lo_valid <= 1'b1;
    end else if (lo_acc[F_WRAP]) begin
      lo_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_IEN:         bus_rdata <= BYTE_W'(ien);
        A_MODE:        bus_rdata <= BYTE_W'(mode);
        A_STAT:        bus_rdata <= BYTE_W'(stat);
        A_CNTH:        bus_rdata <= cnt[CNT_W-1:BYTE_W];
        A_CNTL:        bus_rdata <= lo_valid ? lo_copy : cnt[BYTE_W-1:0];
        A_CAP0H:       bus_rdata <= cap_val[0][CNT_W-1:BYTE_W];
        A_CAP0H + 4'd1: bus_rdata <= cap_val[0][BYTE_W-1:0];
        A_CAP0H + 4'd2: bus_rdata <= cap_val[1][CNT_W-1:BYTE_W];
        A_CAP0H + 4'd3: bus_rdata <= cap_val[1][BYTE_W-1:0];
        default:       bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= |(stat & ien);
  end

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq);
  a_r8_wrap_clear_armed: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_flag) |-> $past(arm[F_WRAP]));
endmodule

// File: tb/pair_timer_tb.sv
module pair_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rdata, rdata2;
  logic [1:0] cap_pin = '0;
  logic [1:0] cmp_pin, cmp_pin2;
  logic       irq, irq2;

  int checks = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0]  d, d2, h, l;
  logic [15:0] c0, capv, cap_first, t;

  always #5 clk = ~clk;

  pair_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .cap_pin(cap_pin),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  pair_timer #(.PRESCALE(1), .CMP_PINS(1'b0)) u_nopin (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .cap_pin(cap_pin),
    .cmp_pin(cmp_pin2), .irq(irq2)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      bad = bad + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, act=%0d exp=<190000", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = rdata; d2 = rdata2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    rd(4'd3); h = d;
    rd(4'd4); v = {h, d};
  endtask

  task automatic t_reset();
    rd(4'd4);
    chk(d == 8'h00, "R1 counter after reset", d, 0);
    rd(4'd2);
    chk(d == 8'h00, "R6 status after reset", d, 0);
    chk(cmp_pin == 2'b00, "R6 pins after reset", cmp_pin, 0);
    chk(irq == 1'b0, "R9 irq after reset", irq, 0);
  endtask

  task automatic t_rate();
    rd(4'd4); l = d;
    wait_n(38);
    rd(4'd4);
    chk(8'(d - l) == 8'd10, "R1 ten counts in forty clocks", 8'(d - l), 10);
  endtask

  task automatic t_latch();
    rd(4'd3);
    wait_n(40);
    rd(4'd4); l = d;
    rd(4'd4);
    chk(8'(d - l) == 8'd11, "R3 low byte frozen by high read", 8'(d - l), 11);
    rd(4'd4); l = d;
    wr(4'd4, 8'h00);
    wr(4'd3, 8'h00);
    rd(4'd4);
    chk(8'(d - l) == 8'd1 || 8'(d - l) == 8'd2, "R3 counter writes ignored", 8'(d - l), 2);
  endtask

  task automatic t_capture();
    wr(4'd1, 8'h0D);
    rd_cnt(c0);
    @(negedge clk); cap_pin[0] = 1'b1;
    wait_n(6);
    rd(4'd2);
    chk(d[1] == 1'b1, "R4 rising capture flag", d[1], 1);
    chk(d[2] == 1'b0, "R4 other channel untouched", d[2], 0);
    chk(irq == 1'b0, "R9 no irq with enables clear", irq, 0);
    rd(4'd5); h = d;
    rd(4'd6); capv = {h, d}; cap_first = capv;
    chk((capv - c0) <= 16'd3, "R4 captured count", capv, c0);
    rd(4'd2);
    chk(d[1] == 1'b0, "R8 capture flag cleared", d[1], 0);
    @(negedge clk); cap_pin[0] = 1'b0;
    wait_n(6);
    rd(4'd2);
    chk(d[1] == 1'b0, "R4 opposite edge ignored", d[1], 0);
    @(negedge clk); cap_pin[1] = 1'b1;
    wait_n(6);
    rd(4'd2);
    chk(d[2] == 1'b0, "R4 rising ignored on falling channel", d[2], 0);
    @(negedge clk); cap_pin[1] = 1'b0;
    wait_n(6);
    wr(4'd0, 8'h04);
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq from falling capture", irq, 1);
    rd(4'd8);
    @(negedge clk);
    chk(irq == 1'b1, "R8 unarmed low read keeps flag", irq, 1);
    rd(4'd2);
    chk(d[2] == 1'b1, "R4 falling capture flag", d[2], 1);
    rd(4'd8);
    @(negedge clk);
    chk(irq == 1'b0, "R8 armed low read clears flag", irq, 0);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_hold();
    rd(4'd5);
    @(negedge clk); cap_pin[0] = 1'b1;
    wait_n(6);
    rd(4'd2);
    chk(d[1] == 1'b0, "R5 capture held off", d[1], 0);
    rd(4'd5); h = d;
    rd(4'd6);
    chk({h, d} == cap_first, "R5 capture value kept", {h, d}, cap_first);
    @(negedge clk); cap_pin[0] = 1'b0;
    wait_n(6);
    @(negedge clk); cap_pin[0] = 1'b1;
    wait_n(6);
    rd(4'd2);
    chk(d[1] == 1'b1, "R5 capture resumes after low read", d[1], 1);
    rd(4'd6);
  endtask

  task automatic t_compare();
    rd_cnt(c0);
    t = c0 + 16'd30;
    wr(4'd9, t[15:8]);
    wr(4'd10, t[7:0]);
    chk(cmp_pin[0] == 1'b0, "R6 pin idle before match", cmp_pin[0], 0);
    wr(4'd0, 8'h08);
    wait_n(140);
    chk(cmp_pin[0] == 1'b1, "R6 pin takes level on match", cmp_pin[0], 1);
    chk(irq == 1'b1, "R9 irq from compare", irq, 1);
    rd(4'd2);
    chk(d[3] == 1'b1, "R6 compare flag", d[3], 1);
    t = c0 + 16'd3000;
    wr(4'd9, t[15:8]);
    wr(4'd10, t[7:0]);
    @(negedge clk);
    chk(irq == 1'b0, "R8 compare flag cleared by low write", irq, 0);
    rd(4'd2);
    chk(d[3] == 1'b0, "R8 status after compare clear", d[3], 0);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_disable();
    rd_cnt(c0);
    t = c0 + 16'd25;
    wr(4'd11, t[15:8]);
    wr(4'd12, t[7:0]);
    wr(4'd11, t[15:8]);
    wait_n(130);
    chk(cmp_pin[1] == 1'b0, "R7 pin quiet while disabled", cmp_pin[1], 0);
    rd(4'd2);
    chk(d[4] == 1'b0, "R7 no flag while disabled", d[4], 0);
    rd_cnt(c0);
    t = c0 + 16'd25;
    wr(4'd11, t[15:8]);
    wr(4'd12, t[7:0]);
    wait_n(130);
    chk(cmp_pin[1] == 1'b1, "R7 match after low write", cmp_pin[1], 1);
    rd(4'd2);
    chk(d[4] == 1'b1, "R7 flag after re-enable", d[4], 1);
  endtask

  task automatic t_wrap();
    int n = 0;
    wr(4'd0, 8'h01);
    while (irq2 !== 1'b1 && n < 70000) begin
      @(negedge clk); n++;
    end
    chk(irq2 == 1'b1, "R2 wrap interrupt", irq2, 1);
    rd(4'd2);
    chk(d2[0] == 1'b1, "R2 wrap flag set", d2[0], 1);
    chk(d[0] == 1'b0, "R2 no wrap before 0xFFFF", d[0], 0);
    rd(4'd4);
    @(negedge clk);
    rd(4'd2);
    chk(d2[0] == 1'b0, "R8 wrap flag cleared", d2[0], 0);
    wait_n(65600);
    rd(4'd2);
    chk(d2[3] == 1'b1, "R10 compare flag without pins", d2[3], 1);
    chk(cmp_pin2 == 2'b00, "R10 pins held low", cmp_pin2, 0);
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    t_reset();
    t_rate();
    t_latch();
    t_capture();
    t_hold();
    t_compare();
    t_disable();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule